// File: doc/BRIEF.md
# Two-level priority interrupt controller

This block arbitrates five interrupt request lines for a small 8-bit processor core. Software sets two byte-wide registers through a simple special-function-register bus. The enable register holds a mask bit for each source and a global enable. The priority register marks each source as high or low class. From the live requests, the masks and the record of what is in service now, the block raises a pending flag and presents the service address of the winning source.

The core tells the block about two events, each with a one-cycle strobe. The acknowledge strobe marks the fetch cycle in which the core takes the pending interrupt. On that cycle the block latches the winner and records its class as in service. The return strobe marks a return from an interrupt routine, and the block then unwinds one level of nesting. A low-class routine can be interrupted by a high-class request. A high-class routine cannot be interrupted at all. The block does no pin edge or level detection, no instruction decode and no stacking of the program counter.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is held and after it is released, with no other activity: both in-service flags are 0, both registers read 0x00, pending is 0, and the vector is 0x003B (stored level 7).
- R2: A write with sfr_we high takes effect at that clock edge. The enable register is at address 0xA8 and the priority register at 0xB8. A read returns the register's contents on sfr_rdata one edge after the address is applied. Any other address reads 0x00, and a write to it changes neither register.
- R3: When bit 7 of the enable register is 0, pending stays 0 whatever the requests are.
- R4: Request line n counts only when bit n (0..4) of the enable register is 1.
- R5: Any enabled request whose priority bit n is 1 (high class) wins over every low-class request. Within a class, the lowest index wins. The level of a source is its index, and 7 means no winner.
- R6: Pending requires that no high-class routine is in service. It also requires that the winner is high class, or that no low-class routine is in service.
- R7: On an accepted acknowledge, the vector becomes the winner's level times 8 plus 3, with the upper 10 bits at zero. Sources 0..4 give 0x0003, 0x000B, 0x0013, 0x001B and 0x0023. The vector does not change at any other time.
- R8: On an accepted acknowledge, serving_hi takes the winner's class (1 for high). serving_lo is set when the winner is low class and otherwise keeps its value.
- R9: A return strobe clears serving_hi if it is set. Otherwise it clears serving_lo.
- R10: When acknowledge and return arrive in the same cycle, only the return acts. The vector keeps its value and the flags unwind as in R9.
- R11: An acknowledge while pending is 0 changes neither the flags nor the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| irq_req | input | 5 | Request lines, one per source |
| sfr_addr | input | 8 | Register bus address |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_we | input | 1 | Register bus write enable |
| sfr_rdata | output | 8 | Registered read data |
| irq_ack | input | 1 | Core takes the pending interrupt this cycle |
| irq_ret | input | 1 | Core returns from an interrupt routine this cycle |
| irq_pending | output | 1 | An interrupt is allowed and waiting |
| irq_vector | output | 16 | Service address of the last accepted source |
| serving_hi | output | 1 | A high-class routine is in service |
| serving_lo | output | 1 | A low-class routine is in service |

## Verification
Pending is combinational. It follows a change on the request lines within the same cycle, and a register write or a flag update right after the edge that makes it. The bench drives inputs on the falling edge and samples pending shortly after. The vector and both flags change on the edge that sees an accepted acknowledge or a return, and read data appears on the edge after the address. The bench therefore checks these at the falling edge that follows that one rising edge. Reset release passes through a two-stage synchronizer, so the bench waits several edges before it applies any stimulus.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Width of the encoded level for a given number of sources; the all-ones
  // code is reserved for "no winner".
  function automatic int lvl_width(input int n_src);
    return $clog2(n_src + 1);
  endfunction

  // Fixed low bits appended to the level to form the service address.
  localparam logic [2:0] VEC_TAIL = 3'b011;

  typedef struct packed {
    logic hi;
    logic lo;
  } svc_t;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  EN_ADDR  = 8'hA8,
  parameter logic [7:0]  PRI_ADDR = 8'hB8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] en_q,
  output logic [DATA_W-1:0] pri_q,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(EN_ADDR);
  localparam logic [ADDR_W-1:0] PRI_A = ADDR_W'(PRI_ADDR);

  logic              hit_en;
  logic              hit_pri;
  logic              en_ce;
  logic              pri_ce;
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    hit_en  = (addr == EN_A);
    hit_pri = (addr == PRI_A);
    en_ce   = we && hit_en;
    pri_ce  = we && hit_pri;
    if (hit_en) begin
      rd_d = en_q;
    end else if (hit_pri) begin
      rd_d = pri_q;
    end else begin
      rd_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
    end else if (pri_ce) begin
      pri_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_d;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC = 5,
  parameter int LVL_W   = irq_pkg::lvl_width(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] en_mask,
  input  logic [NUM_SRC-1:0] pri_mask,
  input  logic               gie,
  input  logic               serving_hi,
  input  logic               serving_lo,
  output logic [LVL_W-1:0]   win_lvl,
  output logic               win_hi,
  output logic               pending
);

  localparam logic [LVL_W-1:0] LVL_NONE = '1;

  logic [NUM_SRC-1:0] any_vec;
  logic [NUM_SRC-1:0] hi_vec;
  logic [LVL_W-1:0]   any_lvl;
  logic [LVL_W-1:0]   hi_lvl;
  logic               allowed;

  always_comb begin
    any_vec = req & en_mask;
    hi_vec  = any_vec & pri_mask;
  end

  // Lowest index wins: scan from the top so the last hit is the smallest.
  always_comb begin
    hi_lvl  = LVL_NONE;
    any_lvl = LVL_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hi_vec[i]) begin
        hi_lvl = LVL_W'(i);
      end
      if (any_vec[i]) begin
        any_lvl = LVL_W'(i);
      end
    end
  end

  always_comb begin
    win_hi  = |hi_vec;
    win_lvl = win_hi ? hi_lvl : any_lvl;
    allowed = !serving_hi && (win_hi || !serving_lo);
    pending = gie && (win_lvl != LVL_NONE) && allowed;
  end

endmodule

// File: rtl/irq_svc.sv
module irq_svc #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             ret,
  input  logic [LVL_W-1:0] win_lvl,
  input  logic             win_hi,
  output logic             serving_hi,
  output logic             serving_lo,
  output logic [VEC_W-1:0] vector
);

  import irq_pkg::*;

  localparam logic [LVL_W-1:0] LVL_NONE = '1;

  svc_t             svc_q;
  svc_t             svc_d;
  logic [LVL_W-1:0] lvl_q;
  logic [LVL_W-1:0] lvl_d;
  logic             lvl_ce;

  // Return outranks acknowledge when both arrive together.
  always_comb begin
    svc_d  = svc_q;
    lvl_d  = lvl_q;
    lvl_ce = 1'b0;
    if (ret) begin
      if (svc_q.hi) begin
        svc_d.hi = 1'b0;
      end else begin
        svc_d.lo = 1'b0;
      end
    end else if (take) begin
      svc_d.hi = win_hi;
      svc_d.lo = svc_q.lo || !win_hi;
      lvl_d    = win_lvl;
      lvl_ce   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_q <= '0;
    end else begin
      svc_q <= svc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LVL_NONE;
    end else if (lvl_ce) begin
      lvl_q <= lvl_d;
    end
  end

  assign serving_hi = svc_q.hi;
  assign serving_lo = svc_q.lo;
  assign vector     = VEC_W'({lvl_q, VEC_TAIL});

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int         NUM_SRC  = 5,
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 8,
  parameter int         VEC_W    = 16,
  parameter logic [7:0] EN_ADDR  = 8'hA8,
  parameter logic [7:0] PRI_ADDR = 8'hB8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [ADDR_W-1:0]  sfr_addr,
  input  logic [DATA_W-1:0]  sfr_wdata,
  input  logic               sfr_we,
  output logic [DATA_W-1:0]  sfr_rdata,
  input  logic               irq_ack,
  input  logic               irq_ret,
  output logic               irq_pending,
  output logic [VEC_W-1:0]   irq_vector,
  output logic               serving_hi,
  output logic               serving_lo
);

  localparam int LVL_W   = irq_pkg::lvl_width(NUM_SRC);
  localparam int GIE_BIT = DATA_W - 1;

  logic              rst_n_sync;
  logic [DATA_W-1:0] en_q;
  logic [DATA_W-1:0] pri_q;
  logic [LVL_W-1:0]  win_lvl;
  logic              win_hi;
  logic              take;

  irq_rst_sync #(
    .STAGES (2)
  ) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  irq_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .EN_ADDR  (EN_ADDR),
    .PRI_ADDR (PRI_ADDR)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .addr  (sfr_addr),
    .wdata (sfr_wdata),
    .we    (sfr_we),
    .en_q  (en_q),
    .pri_q (pri_q),
    .rdata (sfr_rdata)
  );

  irq_arbiter #(
    .NUM_SRC (NUM_SRC),
    .LVL_W   (LVL_W)
  ) u_arb (
    .req        (irq_req),
    .en_mask    (en_q[NUM_SRC-1:0]),
    .pri_mask   (pri_q[NUM_SRC-1:0]),
    .gie        (en_q[GIE_BIT]),
    .serving_hi (serving_hi),
    .serving_lo (serving_lo),
    .win_lvl    (win_lvl),
    .win_hi     (win_hi),
    .pending    (irq_pending)
  );

  assign take = irq_ack && irq_pending;

  irq_svc #(
    .LVL_W (LVL_W),
    .VEC_W (VEC_W)
  ) u_svc (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .take       (take),
    .ret        (irq_ret),
    .win_lvl    (win_lvl),
    .win_hi     (win_hi),
    .serving_hi (serving_hi),
    .serving_lo (serving_lo),
    .vector     (irq_vector)
  );

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NUM_SRC = 5,
  parameter int DATA_W  = 8,
  parameter int VEC_W   = 16
) (
  input logic               clk,
  input logic               rst_n_sync,
  input logic [NUM_SRC-1:0] irq_req,
  input logic [DATA_W-1:0]  en_q,
  input logic               irq_ack,
  input logic               irq_ret,
  input logic               irq_pending,
  input logic [VEC_W-1:0]   irq_vector,
  input logic               serving_hi,
  input logic               serving_lo
);

  p_gie_gates_pending_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    irq_pending |-> en_q[DATA_W-1]);

  p_pending_needs_enabled_req_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    irq_pending |-> (|(irq_req & en_q[NUM_SRC-1:0])));

  p_hi_blocks_all_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    serving_hi |-> !irq_pending);

  p_vector_holds_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(irq_ack && irq_pending && !irq_ret) |=> $stable(irq_vector));

  p_accept_marks_service_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (irq_ack && irq_pending && !irq_ret) |=> (serving_hi || serving_lo));

  p_ret_clears_hi_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (irq_ret && serving_hi) |=> (!serving_hi && $stable(serving_lo)));

  p_ret_clears_lo_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (irq_ret && !serving_hi) |=> (!serving_hi && !serving_lo));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W),
  .VEC_W   (VEC_W)
) u_chk (
  .clk         (clk),
  .rst_n_sync  (rst_n_sync),
  .irq_req     (irq_req),
  .en_q        (en_q),
  .irq_ack     (irq_ack),
  .irq_ret     (irq_ret),
  .irq_pending (irq_pending),
  .irq_vector  (irq_vector),
  .serving_hi  (serving_hi),
  .serving_lo  (serving_lo)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;

  localparam logic [7:0] A_EN  = 8'hA8;
  localparam logic [7:0] A_PRI = 8'hB8;
  localparam int         WDOG  = 150000;

  logic        clk;
  logic        rst_n;
  logic [4:0]  irq_req;
  logic [7:0]  sfr_addr;
  logic [7:0]  sfr_wdata;
  logic        sfr_we;
  logic [7:0]  sfr_rdata;
  logic        irq_ack;
  logic        irq_ret;
  logic        irq_pending;
  logic [15:0] irq_vector;
  logic        serving_hi;
  logic        serving_lo;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  irq_prio_ctrl u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .sfr_addr    (sfr_addr),
    .sfr_wdata   (sfr_wdata),
    .sfr_we      (sfr_we),
    .sfr_rdata   (sfr_rdata),
    .irq_ack     (irq_ack),
    .irq_ret     (irq_ret),
    .irq_pending (irq_pending),
    .irq_vector  (irq_vector),
    .serving_hi  (serving_hi),
    .serving_lo  (serving_lo)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_addr  = a;
    sfr_wdata = d;
    sfr_we    = 1'b1;
    tick();
    sfr_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    sfr_addr = a;
    tick();
    chk(req, "read data", {24'd0, sfr_rdata}, {24'd0, exp});
  endtask

  // Reference arbitration from the requirements.
  function automatic void model(input logic [4:0] req, input logic [4:0] en5,
                                input logic [4:0] pri5, input logic gie,
                                input logic shi, input logic slo,
                                output logic [2:0] lvl, output logic cls,
                                output logic pend);
    logic [4:0] a;
    logic [4:0] h;
    a   = req & en5;
    h   = a & pri5;
    lvl = 3'd7;
    cls = (h != 0);
    for (int i = 4; i >= 0; i--) begin
      if (cls ? h[i] : a[i]) lvl = 3'(i);
    end
    pend = gie && (lvl != 3'd7) && !shi && (cls || !slo);
  endfunction

  // Accept whatever is pending now; returns nothing, checks done by caller.
  task automatic pulse_ack();
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
  endtask

  task automatic pulse_ret();
    irq_ret = 1'b1;
    tick();
    irq_ret = 1'b0;
  endtask

  task automatic sweep_pending(input logic [4:0] en5, input logic [4:0] pri5,
                               input logic gie, input logic shi, input logic slo,
                               input string req_tag);
    logic [2:0] l;
    logic       c;
    logic       p;
    for (int r = 0; r < 32; r++) begin
      irq_req = 5'(r);
      #1;
      model(5'(r), en5, pri5, gie, shi, slo, l, c, p);
      chk(req_tag, "pending", {31'd0, irq_pending}, {31'd0, p});
    end
    irq_req = 5'd0;
  endtask

  initial begin
    logic [2:0]  l;
    logic        c;
    logic        p;
    logic [15:0] v_hold;
    logic [4:0]  en_set [4];
    en_set[0] = 5'h1F; en_set[1] = 5'h15; en_set[2] = 5'h0A; en_set[3] = 5'h00;

    rst_n = 1'b0;
    irq_req = '0; sfr_addr = '0; sfr_wdata = '0; sfr_we = 1'b0;
    irq_ack = 1'b0; irq_ret = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk("R1", "serving_hi in reset", {31'd0, serving_hi}, 32'd0);
    chk("R1", "serving_lo in reset", {31'd0, serving_lo}, 32'd0);
    chk("R1", "vector in reset", {16'd0, irq_vector}, 32'h003B);
    chk("R1", "pending in reset", {31'd0, irq_pending}, 32'd0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1", "vector after release", {16'd0, irq_vector}, 32'h003B);
    rd_chk(A_EN, 8'h00, "R1");
    rd_chk(A_PRI, 8'h00, "R1");

    // R2: register access
    wr(A_EN, 8'h25);
    rd_chk(A_EN, 8'h25, "R2");
    wr(A_PRI, 8'h5A);
    rd_chk(A_PRI, 8'h5A, "R2");
    wr(8'h11, 8'hFF);
    rd_chk(8'h11, 8'h00, "R2");
    rd_chk(A_EN, 8'h25, "R2");
    rd_chk(A_PRI, 8'h5A, "R2");

    // R3: global enable clear blocks everything
    wr(A_EN, 8'h1F);
    wr(A_PRI, 8'h00);
    sweep_pending(5'h1F, 5'h00, 1'b0, 1'b0, 1'b0, "R3");
    wr(A_PRI, 8'h1F);
    sweep_pending(5'h1F, 5'h1F, 1'b0, 1'b0, 1'b0, "R3");

    // R4 R5 R7 R8 R9: sweep enable sets x priority x requests from idle
    for (int e = 0; e < 4; e++) begin
      for (int pr = 0; pr < 32; pr++) begin
        wr(A_EN, {3'b100, en_set[e]});
        wr(A_PRI, {3'b000, 5'(pr)});
        for (int r = 0; r < 32; r++) begin
          irq_req = 5'(r);
          #1;
          model(5'(r), en_set[e], 5'(pr), 1'b1, 1'b0, 1'b0, l, c, p);
          chk("R5", "pending from idle", {31'd0, irq_pending}, {31'd0, p});
          if (p) begin
            pulse_ack();
            chk("R7", "vector", {16'd0, irq_vector}, 32'(l) * 8 + 3);
            chk("R8", "serving_hi", {31'd0, serving_hi}, {31'd0, c});
            chk("R8", "serving_lo", {31'd0, serving_lo}, {31'd0, !c});
            irq_req = 5'd0;
            pulse_ret();
            chk("R9", "flags after return", {30'd0, serving_hi, serving_lo}, 32'd0);
          end
        end
        irq_req = 5'd0;
      end
    end

    // R6 R8 R9: preemption from each in-service state, nested unwind
    wr(A_EN, 8'h9F);
    for (int pr = 0; pr < 32; pr++) begin
      int lo_src;
      int hi_src;
      wr(A_PRI, {3'b000, 5'(pr)});
      lo_src = -1; hi_src = -1;
      for (int i = 4; i >= 0; i--) begin
        if (pr[i]) hi_src = i; else lo_src = i;
      end
      sweep_pending(5'h1F, 5'(pr), 1'b1, 1'b0, 1'b0, "R6");
      if (lo_src >= 0) begin
        irq_req = 5'(1 << lo_src);
        #1;
        pulse_ack();
        irq_req = 5'd0;
        chk("R8", "low accepted", {30'd0, serving_hi, serving_lo}, 32'd1);
        sweep_pending(5'h1F, 5'(pr), 1'b1, 1'b0, 1'b1, "R6");
      end
      if (hi_src >= 0) begin
        irq_req = 5'(1 << hi_src);
        #1;
        pulse_ack();
        irq_req = 5'd0;
        chk("R8", "high accepted, low kept", {30'd0, serving_hi, serving_lo},
            {30'd0, 1'b1, (lo_src >= 0)});
        chk("R7", "nested vector", {16'd0, irq_vector}, 32'(hi_src) * 8 + 3);
        sweep_pending(5'h1F, 5'(pr), 1'b1, 1'b1, (lo_src >= 0), "R6");
        pulse_ret();
        chk("R9", "high unwound first", {30'd0, serving_hi, serving_lo},
            {30'd0, 1'b0, (lo_src >= 0)});
      end
      if (lo_src >= 0) begin
        pulse_ret();
        chk("R9", "low unwound", {30'd0, serving_hi, serving_lo}, 32'd0);
      end
    end

    // R11: acknowledge with nothing pending
    irq_req = 5'd0;
    v_hold = irq_vector;
    pulse_ack();
    chk("R11", "flags", {30'd0, serving_hi, serving_lo}, 32'd0);
    chk("R11", "vector", {16'd0, irq_vector}, {16'd0, v_hold});

    // R10: acknowledge and return together
    wr(A_PRI, 8'h01);
    irq_req = 5'b00100;
    #1;
    pulse_ack();
    chk("R10", "setup low in service", {30'd0, serving_hi, serving_lo}, 32'd1);
    chk("R10", "setup vector", {16'd0, irq_vector}, 32'h0013);
    irq_req = 5'b00001;
    #1;
    chk("R10", "high request pending", {31'd0, irq_pending}, 32'd1);
    irq_ack = 1'b1; irq_ret = 1'b1;
    tick();
    irq_ack = 1'b0; irq_ret = 1'b0;
    chk("R10", "flags after both", {30'd0, serving_hi, serving_lo}, 32'd0);
    chk("R10", "vector after both", {16'd0, irq_vector}, 32'h0013);
    irq_ack = 1'b1; irq_ret = 1'b1;
    tick();
    irq_ack = 1'b0; irq_ret = 1'b0;
    chk("R10", "idle flags after both", {30'd0, serving_hi, serving_lo}, 32'd0);
    chk("R10", "idle vector after both", {16'd0, irq_vector}, 32'h0013);
    irq_req = 5'd0;

    // R4: a disabled source never raises pending
    wr(A_EN, 8'h9E);
    irq_req = 5'b00001;
    #1;
    chk("R4", "disabled source", {31'd0, irq_pending}, 32'd0);
    irq_req = 5'd0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule